// File: doc/BRIEF.md
# Reference Divider and Phase/Frequency Detector

This block sits in the reference path of a frequency synthesizer. It divides the reference clock by one of three ratios picked with two select bits, producing a one-cycle comparison tick per period. A tri-state phase/frequency detector compares that tick with the feedback pulse from the loop's programmable divider and raises pump-up or pump-down requests for an external charge pump.

Three control bits from the host's control register also pass through this block. One disables the pump: both requests are held low while the detector keeps its state. One selects the high or low pump current. One turns the tuning drive off. The ratios 128, 160 and 256 give comparison rates of 31.25, 25 and 15.625 kHz from a 4 MHz reference. Because the synthesizer step is twice the comparison rate, these become steps of 62.5, 50 and 31.25 kHz.

Top module: `synth_ref_pfd`

## Requirements
- R1: With `ratio_lo_i` = 0, `ref_pulse_o` repeats every 160 clock cycles, whatever the value of `ratio_hi_i`.
- R2: With `ratio_hi_i` = 0 and `ratio_lo_i` = 1, `ref_pulse_o` repeats every 256 clock cycles.
- R3: With `ratio_hi_i` = 1 and `ratio_lo_i` = 1, `ref_pulse_o` repeats every 128 clock cycles.
- R4: A change of the select bits does not shorten or stretch the period in progress. The new ratio applies from the next terminal count onward.
- R5: `ref_pulse_o` is high for exactly one clock cycle per period.
- R6: `pump_up_o` rises one cycle after a `ref_pulse_o` cycle and holds until a feedback pulse arrives. `pump_dn_o` rises one cycle after a cycle with `fb_pulse_i` high and holds until a reference tick arrives.
- R7: `pump_up_o` and `pump_dn_o` are never high together. When both detector states would be set, both clear in that cycle, and a reference tick and a feedback pulse in the same cycle raise neither.
- R8: While `pump_off_i` is 1, both pump requests are low. The detector state keeps evolving and shows on the outputs as soon as `pump_off_i` returns to 0.
- R9: `pump_hi_o` equals `pump_hi_i` as sampled at the previous clock edge (1 = high current, 0 = low current).
- R10: `drive_off_o` equals `drive_off_i` as sampled at the previous clock edge (1 = tuning drive off).
- R11: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fb_pulse_i | input | 1 | One-cycle pulse from the programmable feedback divider |
| ratio_hi_i | input | 1 | Upper ratio select bit |
| ratio_lo_i | input | 1 | Lower ratio select bit |
| pump_hi_i | input | 1 | Pump current select from the control register |
| pump_off_i | input | 1 | Pump disable from the control register |
| drive_off_i | input | 1 | Tuning drive disable from the control register |
| ref_pulse_o | output | 1 | Comparison tick from the reference divider |
| pump_up_o | output | 1 | Pump-up request |
| pump_dn_o | output | 1 | Pump-down request |
| pump_hi_o | output | 1 | Registered pump current select |
| drive_off_o | output | 1 | Registered tuning drive disable |

## Verification
A corrupted counter value or a wrongly decoded ratio shows as a tick period off from 128, 160 or 256. It is visible at the second tick after the fault, at most 256 cycles later. A stuck or lost detector state shows within one cycle of the next reference or feedback pulse, as a request that fails to rise, fails to clear, or overlaps the other request. A pump-disable that cleared the state instead of only masking it shows in the cycle it is released, because the held request is then missing.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    RSEL_MID_A = 2'b00,
    RSEL_SLOW  = 2'b01,
    RSEL_MID_B = 2'b10,
    RSEL_FAST  = 2'b11
  } ratio_sel_e;
endpackage

// File: rtl/srp_rst_sync.sv
module srp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/srp_ref_div.sv
module srp_ref_div
  import srp_pkg::*;
#(
  parameter int DIV_MID  = 160,
  parameter int DIV_SLOW = 256,
  parameter int DIV_FAST = 128,
  parameter int CNT_W    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_hi_i,
  input  logic sel_lo_i,
  output logic tick_o
);
  ratio_sel_e       sel;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             at_term;

  assign sel = ratio_sel_e'({sel_hi_i, sel_lo_i});

  always_comb begin
    unique case (sel)
      RSEL_SLOW: load_val = CNT_W'(DIV_SLOW - 1);
      RSEL_FAST: load_val = CNT_W'(DIV_FAST - 1);
      default:   load_val = CNT_W'(DIV_MID - 1);
    endcase
  end

  // The select is sampled only at terminal count, so a period in flight is never cut.
  always_comb begin
    at_term = (cnt_q == '0);
    cnt_d   = at_term ? load_val : cnt_q - 1'b1;
    tick_d  = at_term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/srp_pfd.sv
module srp_pfd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  input  logic fb_tick_i,
  input  logic mask_i,
  output logic up_o,
  output logic dn_o
);
  logic up_q, up_d;
  logic dn_q, dn_d;
  logic up_set, dn_set;

  always_comb begin
    up_set = up_q | ref_tick_i;
    dn_set = dn_q | fb_tick_i;
    if (up_set && dn_set) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end else begin
      up_d = up_set;
      dn_d = dn_set;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  // Masking hides the requests but leaves the detector state running.
  assign up_o = up_q & ~mask_i;
  assign dn_o = dn_q & ~mask_i;
endmodule

// File: rtl/synth_ref_pfd.sv
module synth_ref_pfd #(
  parameter int DIV_MID   = 160,
  parameter int DIV_SLOW  = 256,
  parameter int DIV_FAST  = 128,
  parameter int SYNC_LEN  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fb_pulse_i,
  input  logic ratio_hi_i,
  input  logic ratio_lo_i,
  input  logic pump_hi_i,
  input  logic pump_off_i,
  input  logic drive_off_i,
  output logic ref_pulse_o,
  output logic pump_up_o,
  output logic pump_dn_o,
  output logic pump_hi_o,
  output logic drive_off_o
);
  localparam int DIV_MAX_A = (DIV_MID > DIV_SLOW) ? DIV_MID : DIV_SLOW;
  localparam int DIV_MAX   = (DIV_MAX_A > DIV_FAST) ? DIV_MAX_A : DIV_FAST;
  localparam int CNT_W     = $clog2(DIV_MAX);

  logic rst_sync_n;
  logic ref_tick;
  logic pump_hi_q, pump_hi_d;
  logic drive_off_q, drive_off_d;

  srp_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  srp_ref_div #(
    .DIV_MID  (DIV_MID),
    .DIV_SLOW (DIV_SLOW),
    .DIV_FAST (DIV_FAST),
    .CNT_W    (CNT_W)
  ) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .sel_hi_i (ratio_hi_i),
    .sel_lo_i (ratio_lo_i),
    .tick_o   (ref_tick)
  );

  srp_pfd u_pfd (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .ref_tick_i (ref_tick),
    .fb_tick_i  (fb_pulse_i),
    .mask_i     (pump_off_i),
    .up_o       (pump_up_o),
    .dn_o       (pump_dn_o)
  );

  always_comb begin
    pump_hi_d   = pump_hi_i;
    drive_off_d = drive_off_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pump_hi_q   <= 1'b0;
      drive_off_q <= 1'b0;
    end else begin
      pump_hi_q   <= pump_hi_d;
      drive_off_q <= drive_off_d;
    end
  end

  assign ref_pulse_o = ref_tick;
  assign pump_hi_o   = pump_hi_q;
  assign drive_off_o = drive_off_q;
endmodule

// File: rtl/synth_ref_pfd_chk.sv
module synth_ref_pfd_chk (
  input logic clk_i,
  input logic rst_n,
  input logic fb_pulse_i,
  input logic pump_hi_i,
  input logic pump_off_i,
  input logic drive_off_i,
  input logic ref_pulse_o,
  input logic pump_up_o,
  input logic pump_dn_o,
  input logic pump_hi_o,
  input logic drive_off_o
);
  assert_tick_width_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ref_pulse_o |=> !ref_pulse_o);

  assert_no_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(pump_up_o && pump_dn_o));

  assert_up_follows_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ref_pulse_o && !fb_pulse_i && !pump_dn_o && !pump_off_i) |=> (pump_up_o || pump_off_i));

  assert_pump_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pump_off_i && $past(pump_off_i)) |-> (!pump_up_o && !pump_dn_o));

  assert_current_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> (pump_hi_o == $past(pump_hi_i)));

  assert_drive_off_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> (drive_off_o == $past(drive_off_i)));
endmodule

bind synth_ref_pfd synth_ref_pfd_chk u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .fb_pulse_i  (fb_pulse_i),
  .pump_hi_i   (pump_hi_i),
  .pump_off_i  (pump_off_i),
  .drive_off_i (drive_off_i),
  .ref_pulse_o (ref_pulse_o),
  .pump_up_o   (pump_up_o),
  .pump_dn_o   (pump_dn_o),
  .pump_hi_o   (pump_hi_o),
  .drive_off_o (drive_off_o)
);

// File: tb/sim_synth_ref_pfd.sv
`timescale 1ns/1ps
module sim_synth_ref_pfd;
  logic clk = 1'b0;
  logic rst_n;
  logic fb, r_hi, r_lo, p_hi, p_off, d_off;
  logic ref_pulse, up, dn, p_hi_o, d_off_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  synth_ref_pfd u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fb_pulse_i  (fb),
    .ratio_hi_i  (r_hi),
    .ratio_lo_i  (r_lo),
    .pump_hi_i   (p_hi),
    .pump_off_i  (p_off),
    .drive_off_i (d_off),
    .ref_pulse_o (ref_pulse),
    .pump_up_o   (up),
    .pump_dn_o   (dn),
    .pump_hi_o   (p_hi_o),
    .drive_off_o (d_off_o)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      finish_run();
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!ref_pulse);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ref_pulse);
  endtask

  task automatic set_ratio(input logic hi, input logic lo);
    @(negedge clk);
    r_hi = hi; r_lo = lo;
    wait_tick();
    wait_tick();
  endtask

  // Returns at a negedge with both detector states cleared.
  task automatic align();
    wait_tick();
    fb = 1'b1;
    @(negedge clk);
    fb = 1'b0;
  endtask

  task automatic t_reset_R11();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(ref_pulse, 0, "R11 ref_pulse");
    check(up, 0, "R11 up");
    check(dn, 0, "R11 dn");
    check(p_hi_o, 0, "R11 pump_hi");
    check(d_off_o, 0, "R11 drive_off");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_ratios_R1_R2_R3();
    int n;
    set_ratio(1'b0, 1'b0); measure(n); check(n, 160, "R1 sel 00");
    set_ratio(1'b1, 1'b0); measure(n); check(n, 160, "R1 sel 10");
    set_ratio(1'b0, 1'b1); measure(n); check(n, 256, "R2 sel 01");
    set_ratio(1'b1, 1'b1); measure(n); check(n, 128, "R3 sel 11");
  endtask

  task automatic t_width_R5();
    wait_tick();
    @(negedge clk);
    check(ref_pulse, 0, "R5 pulse one cycle");
  endtask

  task automatic t_change_R4();
    int n;
    set_ratio(1'b1, 1'b1);
    wait_tick();
    r_hi = 1'b0; r_lo = 1'b1;
    measure(n); check(n, 128, "R4 running period kept");
    measure(n); check(n, 256, "R4 new ratio next period");
    set_ratio(1'b1, 1'b1);
  endtask

  task automatic t_up_R6();
    align();
    check(up, 0, "R7 same-cycle up");
    check(dn, 0, "R7 same-cycle dn");
    wait_tick();
    @(negedge clk);
    check(up, 1, "R6 up after tick");
    check(dn, 0, "R6 dn idle");
    repeat (5) @(negedge clk);
    check(up, 1, "R6 up held");
    fb = 1'b1;
    @(negedge clk);
    fb = 1'b0;
    check(up, 0, "R7 up cleared");
    check(dn, 0, "R7 dn cleared");
  endtask

  task automatic t_dn_R6();
    align();
    fb = 1'b1;
    @(negedge clk);
    fb = 1'b0;
    check(dn, 1, "R6 dn after feedback");
    check(up, 0, "R6 up idle");
    wait_tick();
    check(dn, 1, "R6 dn held to tick");
    @(negedge clk);
    check(dn, 0, "R7 dn cleared by tick");
    check(up, 0, "R7 up not raised");
  endtask

  task automatic t_mask_R8();
    align();
    p_off = 1'b1;
    wait_tick();
    @(negedge clk);
    check(up, 0, "R8 up masked");
    check(dn, 0, "R8 dn masked");
    p_off = 1'b0;
    #1;
    check(up, 1, "R8 state kept under mask");
    fb = 1'b1;
    @(negedge clk);
    fb = 1'b0;
    check(up, 0, "R8 cleared after release");
  endtask

  task automatic t_ctrl_R9_R10();
    @(negedge clk);
    p_hi = 1'b1; d_off = 1'b1;
    #1;
    check(p_hi_o, 0, "R9 not before edge");
    check(d_off_o, 0, "R10 not before edge");
    @(negedge clk);
    check(p_hi_o, 1, "R9 high current");
    check(d_off_o, 1, "R10 drive off");
    p_hi = 1'b0;
    @(negedge clk);
    check(p_hi_o, 0, "R9 low current");
    check(d_off_o, 1, "R10 held");
    d_off = 1'b0;
    @(negedge clk);
    check(d_off_o, 0, "R10 drive on");
  endtask

  initial begin
    rst_n = 1'b0;
    fb = 1'b0; r_hi = 1'b1; r_lo = 1'b1;
    p_hi = 1'b0; p_off = 1'b0; d_off = 1'b0;
    t_reset_R11();
    t_ratios_R1_R2_R3();
    t_width_R5();
    t_change_R4();
    t_up_R6();
    t_dn_R6();
    t_mask_R8();
    t_ctrl_R9_R10();
    finish_run();
  end
endmodule